// File: doc/BRIEF.md
# Three-Group Staggered Grayscale PWM Controller

This block drives 24 on/off channel outputs, arranged as three colour groups (red, green, blue) of eight channels each. Each group has its own reference clock input and its own 12-bit grayscale counter. The block samples each group clock in the system clock domain. Every rising edge it detects advances that group's counter by one, and the counter saturates at full scale. A channel is driven on while its group counter is below the channel's 12-bit grayscale value.

An active-low blank input forces every output off. It also clears all three counters and the internal timing pipeline. Releasing blank starts a new PWM period from count zero.

Within a group the eight channels form four pairs: channels c and c+4 make pair c. Pair p switches p times a parameterised stagger after pair 0, counted in system clock cycles. This spreads the switching edges of a group across several cycles instead of landing them all in one.

Top module: `tri_group_pwm`

## Requirements
- R1: Under reset, all counters, edge detectors and stagger pipelines are cleared. With blank low, every output is 0.
- R2: A group clock passes through SYNC_STAGES synchronizer flops (default 2). A low-to-high change driven during system cycle j advances the counter seen in cycle j+SYNC_STAGES+1. The counter advances by exactly one per rising edge, a clock held high counts once, and each group counts only its own clock.
- R3: Channel c of group g is on while that group's counter is strictly below the channel's grayscale value. A value of 0 never turns the channel on. A value of 4095 is on for counts 0 to 4094.
- R4: A counter that reaches 4095 holds there until the next blank. It never wraps to 0.
- R5: While blank_ni is 0, all 24 outputs are 0 in that same cycle. Every counter reads 0 in the following cycle.
- R6: Blank clears the stagger pipeline. After blank_ni returns to 1, a pair with delay D stays off until D cycles have passed with blank_ni continuously at 1.
- R7: Pair p is channels p and p+4. Its output in cycle k is the counter comparison from cycle k-p*STAGGER (STAGGER default 2). It is gated by blank_ni having been 1 from cycle k-p*STAGGER through cycle k.
- R8: Output bit g*8+c is channel c of group g, with group 0 red, 1 green and 2 blue. Its grayscale value is gs_i[(g*8+c)*12 +: 12], and group g counts on grp_clk_i[g].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_clk_i | input | 3 | Reference clocks per group (0 red, 1 green, 2 blue) |
| blank_ni | input | 1 | Active-low blank: 0 forces outputs off and reinitialises timing |
| gs_i | input | 288 | Twenty-four 12-bit grayscale values, channel g*8+c at bits (g*8+c)*12 |
| drive_o | output | 24 | Channel on/off drive, bit g*8+c |

## Verification
The bench runs the red group far past full scale, so a wrapping counter would turn its 4095 and near-full channels back on. It holds the blue clock high for thousands of cycles, where level counting instead of edge counting would race that group's counter. Short single-cycle blanks and multi-cycle blanks are placed so that a pipeline that is not cleared would leak stale on-states from the delayed pairs, and a missing output gate would show a stray on during blank. Per-group clock rates and per-group grayscale values make a swapped group or pair mapping, or an off-by-one stagger depth, fail on the first transition.

// File: rtl/tgp_pkg.sv
package tgp_pkg;
  localparam int unsigned NUM_GROUPS      = 3;
  localparam int unsigned CH_PER_GROUP    = 8;
  localparam int unsigned PAIRS_PER_GROUP = CH_PER_GROUP / 2;
  localparam int unsigned NUM_CH          = NUM_GROUPS * CH_PER_GROUP;
endpackage

// File: rtl/tgp_edge_sync.sv
module tgp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic samp;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign samp = async_i;
    end else begin : g_sync
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sync_q <= '0;
        end else begin
          sync_q[0] <= async_i;
          for (int i = 1; i < int'(STAGES); i++) sync_q[i] <= sync_q[i-1];
        end
      end
      assign samp = sync_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= samp;
  end

  assign rise_o = samp & ~prev_q;

  // R2
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tgp_gs_counter.sv
module tgp_gs_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         blank_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!blank_ni)                 cnt_q <= '0;
    else if (step_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R5
  blank_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |=> cnt_q == '0);
  // R4
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R2
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && step_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tgp_pair_delay.sv
module tgp_pair_delay #(
  parameter int unsigned DEPTH = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       blank_ni,
  input  logic [1:0] in_i,
  output logic [1:0] out_o
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign out_o = in_i;
    end else begin : g_line
      logic [DEPTH-1:0][1:0] line_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          line_q <= '0;
        end else if (!blank_ni) begin
          line_q <= '0;
        end else begin
          line_q[0] <= in_i;
          for (int i = 1; i < int'(DEPTH); i++) line_q[i] <= line_q[i-1];
        end
      end
      assign out_o = line_q[DEPTH-1];

      // R6
      line_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !blank_ni |=> out_o == 2'b00);
    end
  endgenerate
endmodule

// File: rtl/tgp_group.sv
module tgp_group
  import tgp_pkg::*;
#(
  parameter int unsigned W       = 12,
  parameter int unsigned STAGGER = 2,
  parameter int unsigned SYNC    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ref_clk_i,
  input  logic                      blank_ni,
  input  logic [CH_PER_GROUP*W-1:0] gs_i,
  output logic [CH_PER_GROUP-1:0]   drive_o
);
  logic                    step;
  logic [W-1:0]            cnt;
  logic [CH_PER_GROUP-1:0] raw;

  tgp_edge_sync #(.STAGES(SYNC)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ref_clk_i),
    .rise_o  (step)
  );

  tgp_gs_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .blank_ni (blank_ni),
    .step_i   (step),
    .cnt_o    (cnt)
  );

  for (genvar c = 0; c < CH_PER_GROUP; c++) begin : g_cmp
    assign raw[c] = cnt < gs_i[c*W +: W];
  end

  for (genvar p = 0; p < PAIRS_PER_GROUP; p++) begin : g_pair
    logic [1:0] dly;
    tgp_pair_delay #(.DEPTH(p*STAGGER)) u_dly (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .blank_ni (blank_ni),
      .in_i     ({raw[p+PAIRS_PER_GROUP], raw[p]}),
      .out_o    (dly)
    );
    assign drive_o[p]                 = blank_ni & dly[0];
    assign drive_o[p+PAIRS_PER_GROUP] = blank_ni & dly[1];
  end

  // R3
  lead_pair_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o[0] |-> (cnt < gs_i[W-1:0]));
endmodule

// File: rtl/tri_group_pwm.sv
module tri_group_pwm
  import tgp_pkg::*;
#(
  parameter int unsigned GS_W        = 12,
  parameter int unsigned STAGGER     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_GROUPS-1:0]  grp_clk_i,
  input  logic                   blank_ni,
  input  logic [NUM_CH*GS_W-1:0] gs_i,
  output logic [NUM_CH-1:0]      drive_o
);
  localparam int unsigned GRP_BITS = CH_PER_GROUP * GS_W;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    tgp_group #(
      .W       (GS_W),
      .STAGGER (STAGGER),
      .SYNC    (SYNC_STAGES)
    ) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ref_clk_i (grp_clk_i[g]),
      .blank_ni  (blank_ni),
      .gs_i      (gs_i[g*GRP_BITS +: GRP_BITS]),
      .drive_o   (drive_o[g*CH_PER_GROUP +: CH_PER_GROUP])
    );
  end

  // R5
  blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |-> drive_o == '0);
  // R1
  always_comb begin
    if (!rst_ni && !blank_ni) reset_off_chk: assert (drive_o == '0);
  end
endmodule

// File: tb/tri_group_pwm_test.sv
module tri_group_pwm_test;
  localparam int CLK_PERIOD = 10;
  localparam int GS_W       = 12;
  localparam int STAGGER    = 2;
  localparam int SYNC       = 2;
  localparam int NG         = 3;
  localparam int NC         = 24;
  localparam int HIST       = 32;
  localparam int GS_MAX     = 4095;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              blank_n = 1'b0;
  logic [NG-1:0]     gclk = '0;
  logic [NC*GS_W-1:0] gs = '0;
  logic [NC-1:0]     drive;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int cnt_m [NG];
  int cnt_hist [NG][HIST];
  bit g_hist [NG][HIST];
  bit b_hist [HIST];
  int gsv [NC];

  tri_group_pwm #(.GS_W(GS_W), .STAGGER(STAGGER), .SYNC_STAGES(SYNC)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .grp_clk_i (gclk),
    .blank_ni  (blank_n),
    .gs_i      (gs),
    .drive_o   (drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit g_at(int g, int k);
    if (k < 0) return 1'b0;
    return g_hist[g][k % HIST];
  endfunction

  function automatic bit b_at(int k);
    if (k < 0) return 1'b0;
    return b_hist[k % HIST];
  endfunction

  task automatic set_gs();
    for (int i = 0; i < NC; i++) gs[i*GS_W +: GS_W] = gsv[i][GS_W-1:0];
  endtask

  task automatic check_outputs(input string ph);
    for (int g = 0; g < NG; g++) begin
      for (int c = 0; c < 8; c++) begin
        int d;
        bit win;
        bit exp;
        string tag;
        int cv;
        d = (c % 4) * STAGGER;
        win = 1'b1;
        for (int j = cyc - d; j <= cyc; j++) if (!b_at(j)) win = 1'b0;
        cv = (cyc - d >= 0) ? cnt_hist[g][(cyc - d) % HIST] : 0;
        exp = win && (cv < gsv[g*8+c]);
        if (!b_at(cyc))                 tag = "R5";
        else if (!win)                  tag = "R6";
        else if (cv == GS_MAX)          tag = "R4";
        else if (gsv[g*8+c] == 0)       tag = "R3";
        else if (d > 0)                 tag = "R7";
        else                            tag = "R3";
        checks++;
        if (drive[g*8+c] !== exp) begin
          errors++;
          $display("FAIL %s/%s cyc %0d grp %0d ch %0d: drive=%b expected=%b", tag, ph,
                   cyc, g, c, drive[g*8+c], exp);
        end
      end
    end
  endtask

  task automatic tick(input bit nb, input logic [NG-1:0] ng, input string ph);
    @(negedge clk);
    blank_n = nb;
    gclk = ng;
    b_hist[cyc % HIST] = nb;
    for (int g = 0; g < NG; g++) begin
      g_hist[g][cyc % HIST] = ng[g];
      cnt_hist[g][cyc % HIST] = cnt_m[g];
    end
    #1;
    check_outputs(ph);
    @(posedge clk);
    for (int g = 0; g < NG; g++) begin
      if (!nb) cnt_m[g] = 0;
      else if (g_at(g, cyc - SYNC) && !g_at(g, cyc - SYNC - 1) && cnt_m[g] < GS_MAX)
        cnt_m[g] = cnt_m[g] + 1;
    end
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NG-1:0] ng;
    for (int g = 0; g < NG; g++) cnt_m[g] = 0;
    for (int g = 0; g < NG; g++)
      for (int c = 0; c < 8; c++) begin
        case (c)
          0: gsv[g*8+c] = 0;
          1: gsv[g*8+c] = 1;
          2: gsv[g*8+c] = 4095;
          3: gsv[g*8+c] = 7 + 5*g;
          4: gsv[g*8+c] = 2048;
          5: gsv[g*8+c] = 4094;
          6: gsv[g*8+c] = 300 * (g + 1);
          default: gsv[g*8+c] = 4000 - g;
        endcase
      end
    set_gs();

    // R1: reset state with blank low
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (drive !== '0) begin
      errors++;
      $display("FAIL R1 reset: drive=%h expected=%h", drive, 24'h0);
    end
    rst_n = 1'b1;

    // R2, R3, R4, R7: different rates per group, blue held high later
    for (int t = 0; t < 8300; t++) begin
      ng[0] = t[0];
      ng[1] = t[1];
      ng[2] = (t < 600) ? (((t / 3) % 2) == 1) : 1'b1;
      tick(1'b1, ng, "R2");
    end

    // R5, R6: short and long blanks while clocks run
    for (int t = 0; t < 60; t++) begin
      ng = {3{t[0]}};
      tick(!(t == 5 || (t >= 20 && t < 25) || t == 40), ng, "R6");
    end

    // R8: new values loaded during blank
    tick(1'b0, '0, "R5");
    for (int i = 0; i < NC; i++) gsv[i] = (i * 173 + 5) % 4096;
    gsv[NC-1] = 4095;
    gsv[8] = 0;
    set_gs();
    for (int t = 0; t < 10; t++) tick(1'b0, '0, "R5");

    // R4, R8: all groups together to saturation and beyond
    for (int t = 0; t < 8400; t++) begin
      ng = {3{t[0]}};
      tick(1'b1, ng, "R8");
    end
    for (int t = 0; t < 12; t++) tick(t >= 1, '0, "R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule